// File: doc/BRIEF.md
# Configurable 2/3-Wire Serial Port

This block is a shift-register serial port for short transfers of 4 or 8 bits. Software programs a control register with the wire mode, word length, bit order, shift-clock source and active clock edge. Writing the data register starts a transfer. When the last bit has been exchanged the port raises a level interrupt, and reading the received word clears it. In 3-wire mode the clock and data-out pins are driven push-pull and received bits come from a separate input. In 2-wire mode both the clock and the data pin are open-drain: the outputs only ever pull low or release, so a shared line can be read back through one of the two data-in pins.

The shift clock is either generated internally, as half-periods derived from the system clock at one of four rates, or taken from the clock pin. In the external case the pin passes through a two-flop synchronizer and edge detector. A single state machine steps through the transfer. In ST_IDLE it waits, and a data write not refused moves it to ST_SETUP. ST_SETUP holds the clock at its idle level, and an active-edge event moves it to ST_HOLD, where the input is sampled and the output advances. ST_HOLD holds the clock at its active level, and an inactive-edge event returns it to ST_SETUP, or moves it to ST_FINISH once all bits are done. ST_FINISH lasts one cycle, sets the interrupt and returns to ST_IDLE.

Top module: `sio_port`

## Requirements
- R1: Control bit 1 selects the word length (0 = 4 bits in data bits [3:0], 1 = 8 bits): a transfer has exactly that many active clock edges, and the received word reads back with the unused upper bits as zero.
- R2: Control bit 2 selects the order (0 = most significant bit first, 1 = least significant bit first) for both the transmitted and the received bits.
- R3: With the internal clock, control bits [7:6] = 0, 1, 2, 3 give a clock half-period of 5, 10, 15 and 30 system cycles (system clock divided by 10, 20, 30 and 60).
- R4: Control bit 3 = 1 takes the shift clock from `sck_in` through a two-flop synchronizer: the port never drives the clock pin (`sck_oe` = 0), and each synchronized active edge shifts one bit.
- R5: Control bit 4 selects the active edge (0 = rising with the clock idle low, 1 = falling with the clock idle high). On the active edge the selected input is sampled and the next output bit is presented. The first bit is on the data pin before the first active edge.
- R6: Control bit 0 = 1 selects 2-wire mode: `sck_out` and `sdo_out` stay 0, and a high level is produced only by releasing the output enable.
- R7: Control bit 5 selects the receive pin (0 = `din_a`, 1 = `din_b`).
- R8: Register map: address 0 control, address 1 status (bit 0 busy, bit 1 interrupt flag), address 2 data. At the end of a transfer busy clears and `irq` rises. A read of address 2 returns the received word and clears the flag.
- R9: While busy, writes to the data and control registers are ignored.
- R10: After reset the control register, status, data and `irq` are all 0. The clock pin is driven low and the data pin is driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the flag on a data read) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Transfer-complete interrupt request |
| sck_in | input | 1 | Level sensed on the clock pin |
| sck_out | output | 1 | Clock pin output value |
| sck_oe | output | 1 | Clock pin output enable |
| sdo_out | output | 1 | Data pin output value |
| sdo_oe | output | 1 | Data pin output enable |
| din_a | input | 1 | Receive data pin A |
| din_b | input | 1 | Receive data pin B |

## Verification
A data write lands on the clock edge where the strobe is seen, so the first clock transition is due one half-period later. The bench samples every falling system-clock edge and measures the gap between the first two transitions against the rate table. In external mode the synchronizer and edge detector add three cycles between a pin change and the shift. The bench therefore changes `din_b` only just before its next active edge, and reads `sdo_out` four or more cycles after the previous one. `irq` follows the last inactive edge through ST_FINISH one cycle later, so the bench polls `irq` with a bounded loop rather than at a fixed cycle, then reads the data and status registers.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HOLD,
        ST_FINISH
    } sio_state_t;

    typedef struct packed {
        logic [1:0] rate;
        logic       din_sel;
        logic       fall_edge;
        logic       ext_clk;
        logic       lsb_first;
        logic       len8;
        logic       two_wire;
    } sio_ctrl_t;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_STATUS = 2'd1;
    localparam logic [1:0] ADDR_DATA   = 2'd2;

endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen #(
    parameter int HALF_BASE = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    input  logic       ext_clk,
    input  logic       fall_edge,
    input  logic       sck_in,
    output logic       tick,
    output logic       ext_act,
    output logic       ext_inact
);
    localparam int MAX_HALF = HALF_BASE * 6;
    localparam int CW       = $clog2(MAX_HALF + 1);

    logic [CW-1:0] half_len;
    logic [CW-1:0] cnt_q;
    logic          s1_q, s2_q, s3_q;
    logic          rise, fall;

    always_comb begin
        unique case (rate)
            2'd0: half_len = CW'(HALF_BASE);
            2'd1: half_len = CW'(HALF_BASE * 2);
            2'd2: half_len = CW'(HALF_BASE * 3);
            2'd3: half_len = CW'(HALF_BASE * 6);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || ext_clk || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign tick = run && !ext_clk && (cnt_q == half_len - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= sck_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise      = s2_q && !s3_q;
    assign fall      = !s2_q && s3_q;
    assign ext_act   = run && ext_clk && (fall_edge ? fall : rise);
    assign ext_inact = run && ext_clk && (fall_edge ? rise : fall);

    // R3: internal half-period ticks never come on consecutive cycles
    p_tick_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R4: a synchronized pin edge yields a single-cycle event
    p_ext_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_act |=> !ext_act);

endmodule

// File: rtl/sio_shreg.sv
module sio_shreg #(
    parameter int W       = 8,
    parameter int SHORT_W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         lsb_first,
    input  logic         len8,
    input  logic         din,
    output logic         out_bit,
    output logic [W-1:0] word
);
    localparam logic [W-1:0] SHORT_MASK = W'((1 << SHORT_W) - 1);

    logic [W-1:0] sr_q;
    logic [W-1:0] nxt;

    always_comb begin
        if (lsb_first) begin
            nxt = sr_q >> 1;
            if (len8) nxt[W-1] = din;
            else      nxt[SHORT_W-1] = din;
        end else begin
            nxt = {sr_q[W-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sr_q <= '0;
        else if (load)  sr_q <= load_val;
        else if (shift) sr_q <= nxt;
    end

    assign out_bit = lsb_first ? sr_q[0] : (len8 ? sr_q[W-1] : sr_q[SHORT_W-1]);
    assign word    = len8 ? sr_q : (sr_q & SHORT_MASK);

endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SHORT_W   = 4,
    parameter int HALF_BASE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    output logic              sdo_out,
    output logic              sdo_oe,
    input  logic              din_a,
    input  logic              din_b
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    sio_state_t        state_q, state_d;
    sio_ctrl_t         ctrl_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CNT_W-1:0]  nbits;
    logic              irq_q;
    logic              busy, start, step, ret, shift, run;
    logic              tick, ext_act, ext_inact;
    logic              out_bit, din_sel, sck_lvl, sdo_bit;
    logic [DATA_W-1:0] word;

    assign busy  = (state_q != ST_IDLE);
    assign start = reg_wr && (reg_addr == ADDR_DATA) && !busy;
    assign run   = (state_q == ST_SETUP) || (state_q == ST_HOLD);
    assign nbits = ctrl_q.len8 ? CNT_W'(DATA_W) : CNT_W'(SHORT_W);
    assign step  = ctrl_q.ext_clk ? ext_act   : tick;
    assign ret   = ctrl_q.ext_clk ? ext_inact : tick;
    assign shift = (state_q == ST_SETUP) && step;
    assign din_sel = ctrl_q.din_sel ? din_b : din_a;

    sio_clkgen #(.HALF_BASE(HALF_BASE)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .rate      (ctrl_q.rate),
        .ext_clk   (ctrl_q.ext_clk),
        .fall_edge (ctrl_q.fall_edge),
        .sck_in    (sck_in),
        .tick      (tick),
        .ext_act   (ext_act),
        .ext_inact (ext_inact)
    );

    sio_shreg #(.W(DATA_W), .SHORT_W(SHORT_W)) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_val  (reg_wdata),
        .shift     (shift),
        .lsb_first (ctrl_q.lsb_first),
        .len8      (ctrl_q.len8),
        .din       (din_sel),
        .out_bit   (out_bit),
        .word      (word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SETUP;
            ST_SETUP:  if (step)  state_d = ST_HOLD;
            ST_HOLD:   if (ret)   state_d = (bit_cnt == nbits) ? ST_FINISH : ST_SETUP;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    // control, bit counter and interrupt flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            bit_cnt <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (reg_wr && (reg_addr == ADDR_CTRL) && !busy)
                ctrl_q <= sio_ctrl_t'(reg_wdata[7:0]);
            if (start)      bit_cnt <= '0;
            else if (shift) bit_cnt <= bit_cnt + CNT_W'(1);
            if (state_q == ST_FINISH)
                irq_q <= 1'b1;
            else if (reg_rd && (reg_addr == ADDR_DATA))
                irq_q <= 1'b0;
        end
    end

    // pin outputs
    always_comb begin
        sck_lvl = (state_q == ST_HOLD) ^ ctrl_q.fall_edge;
        sdo_bit = run ? out_bit : 1'b1;
        if (ctrl_q.ext_clk) begin
            sck_out = 1'b0;
            sck_oe  = 1'b0;
        end else if (ctrl_q.two_wire) begin
            sck_out = 1'b0;
            sck_oe  = !sck_lvl;
        end else begin
            sck_out = sck_lvl;
            sck_oe  = 1'b1;
        end
        if (ctrl_q.two_wire) begin
            sdo_out = 1'b0;
            sdo_oe  = !sdo_bit;
        end else begin
            sdo_out = sdo_bit;
            sdo_oe  = 1'b1;
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL:   reg_rdata = DATA_W'(ctrl_q);
            ADDR_STATUS: reg_rdata = {{(DATA_W-2){1'b0}}, irq_q, busy};
            ADDR_DATA:   reg_rdata = word;
            default:     reg_rdata = '0;
        endcase
    end

    assign irq = irq_q;

    // R1: never more shifts than the selected word length
    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bit_cnt <= nbits));

    // R8: leaving the finish state always leaves the interrupt raised
    p_finish_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |=> irq_q);

    // R9: control stays frozen while a transfer runs
    p_ctrl_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctrl_q));

endmodule

// File: tb/tb_sio_port.sv
module tb_sio_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, sck_out, sck_oe, sdo_out, sdo_oe;
    logic       use_ext = 1'b0;
    logic       ext_sck = 1'b1;
    logic       din_b = 1'b0;
    logic       sck_pin, sdo_pin;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    assign sck_pin = use_ext ? ext_sck : (sck_oe ? sck_out : 1'b1);
    assign sdo_pin = sdo_oe ? sdo_out : 1'b1;

    sio_port dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .sck_in(sck_pin), .sck_out(sck_out), .sck_oe(sck_oe),
        .sdo_out(sdo_out), .sdo_oe(sdo_oe), .din_a(sdo_pin), .din_b(din_b)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [7:0] rev(input logic [7:0] v, input int n);
        logic [7:0] r = '0;
        for (int k = 0; k < n; k++) r[n-1-k] = v[k];
        return r;
    endfunction

    task automatic wait_irq(input string req);
        int i = 0;
        while (!irq && i < 200) begin
            @(negedge clk);
            i++;
        end
        chk(req, irq, 1'b1);
    endtask

    // internal clock transfer with pin observation
    task automatic run_internal(input string tag, input logic [7:0] ctrl,
                                input logic [7:0] tx, input logic [7:0] exp_rx);
        int   n    = ctrl[1] ? 8 : 4;
        int   half = (ctrl[7:6] == 0) ? 5 : (ctrl[7:6] == 1) ? 10 : (ctrl[7:6] == 2) ? 15 : 30;
        logic idle = ctrl[4];
        logic [7:0] mask = ctrl[1] ? 8'hFF : 8'h0F;
        logic [7:0] seq = '0;
        logic [7:0] rd;
        logic prev_sck, prev_sdo, od_bad;
        int   i = 0, t1 = -1, t2 = -1, act_edges = 0;
        reg_write(2'd0, ctrl);
        reg_write(2'd2, tx);
        chk({tag, " R5 idle level"}, sck_pin, idle);
        prev_sck = sck_pin;
        prev_sdo = sdo_pin;
        od_bad   = 1'b0;
        while (!irq && i < 3000) begin
            @(negedge clk);
            i++;
            if (ctrl[0] && (sck_out || sdo_out)) od_bad = 1'b1;
            if (sck_pin != prev_sck) begin
                if (t1 < 0) t1 = i; else if (t2 < 0) t2 = i;
                if (sck_pin == !idle) begin
                    act_edges++;
                    seq = {seq[6:0], prev_sdo};
                end
            end
            prev_sck = sck_pin;
            prev_sdo = sdo_pin;
        end
        chk({tag, " R8 irq raised"}, irq, 1'b1);
        chk({tag, " R1 active edges"}, act_edges, n);
        chk({tag, " R3 half period"}, t2 - t1, half);
        chk({tag, " R2 bit order"}, seq, ctrl[2] ? rev(tx, n) : (tx & mask));
        if (ctrl[0]) chk({tag, " R6 open drain never high"}, od_bad, 1'b0);
        reg_read(2'd2, rd);
        chk({tag, " R8 R7 rx word"}, rd, exp_rx);
        reg_read(2'd1, rd);
        chk({tag, " R8 status after read"}, rd, 8'h00);
    endtask

    task automatic t_reset;
        logic [7:0] rd;
        chk("R10 sck_out", sck_out, 1'b0);
        chk("R10 sck_oe", sck_oe, 1'b1);
        chk("R10 sdo_out", sdo_out, 1'b1);
        chk("R10 sdo_oe", sdo_oe, 1'b1);
        chk("R10 irq", irq, 1'b0);
        reg_read(2'd0, rd); chk("R10 ctrl", rd, 8'h00);
        reg_read(2'd1, rd); chk("R10 status", rd, 8'h00);
        reg_read(2'd2, rd); chk("R10 data", rd, 8'h00);
    endtask

    task automatic t_busy_ignore;
        logic [7:0] rd;
        reg_write(2'd0, 8'h02);
        reg_write(2'd2, 8'h5A);
        repeat (20) @(negedge clk);
        reg_read(2'd1, rd);
        chk("R8 busy during transfer", rd, 8'h01);
        reg_write(2'd2, 8'hFF);
        reg_write(2'd0, 8'hC3);
        wait_irq("R9 irq");
        reg_read(2'd0, rd);
        chk("R9 ctrl write ignored", rd, 8'h02);
        reg_read(2'd2, rd);
        chk("R9 data write ignored", rd, 8'h5A);
    endtask

    task automatic t_external;
        logic [7:0] rd;
        logic [3:0] tx  = 4'hA;
        logic [3:0] pat = 4'h6;
        logic [3:0] seen = '0;
        ext_sck = 1'b1;
        use_ext = 1'b1;
        repeat (4) @(negedge clk);
        reg_write(2'd0, 8'h3C);
        reg_write(2'd2, {4'h0, tx});
        for (int k = 0; k < 4; k++) begin
            din_b = pat[k];
            repeat (4) @(negedge clk);
            seen[k] = sdo_pin;
            chk("R4 clock pin not driven", sck_oe, 1'b0);
            ext_sck = 1'b0;
            repeat (6) @(negedge clk);
            ext_sck = 1'b1;
            repeat (6) @(negedge clk);
        end
        chk("R4 R2 R5 lsb-first output bits", seen, tx);
        wait_irq("R4 irq");
        reg_read(2'd2, rd);
        chk("R4 R7 rx from din_b", rd, {4'h0, pat});
        use_ext = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_internal("msb8 rate0", 8'h02, 8'hA5, 8'hA5);
        run_internal("lsb4 rate1", 8'h44, 8'h3C, 8'h0C);
        run_internal("2wire fall rate2", 8'h93, 8'h6B, 8'h6B);
        run_internal("msb4 rate3", 8'hC0, 8'h09, 8'h09);
        din_b = 1'b1;
        run_internal("din_b select", 8'h22, 8'h00, 8'hFF);
        din_b = 1'b0;
        t_busy_ignore();
        t_external();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule